// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the horizontal and vertical timing of a CRT raster from a small set of memory-mapped registers. A horizontal counter steps once per pixel clock across a programmable line length. When it wraps it advances a vertical counter, which in turn wraps at a programmable frame length. Three outputs are decoded from the two counters: the horizontal sync pulse, the vertical sync pulse and an active-video strobe. The current pixel coordinates come out as well. The current line number can be read back through the register read port.

Software writes through a plain single-cycle write port and reads through a combinational read port. Each write is masked to the bits the register implements. Writes land in a shadow copy, which is readable at once. The counters use a working copy, which takes the shadow contents only at a frame boundary or while the raster is stopped. A write made during a frame therefore never disturbs the raster already in progress.

Register map (word index on `wr_addr`/`rd_addr`):

| Index | Register | Write mask |
|---|---|---|
| 0 | control | 0x0003FFFF |
| 1 | horizontal total | 0x0FFF0FFF |
| 2 | horizontal sync | 0x00FF0FFF |
| 3 | vertical total | 0x0FFF0FFF |
| 4 | vertical sync | 0x003F0FFF |
| 5 | current line | read-only |

Field layout:

- Total registers: bits 11:0 hold the active size minus one, and bits 27:16 hold the full length minus one.
- Sync registers: bits 11:0 hold the first counter value of the pulse, and the upper field holds the pulse width (bits 23:16 horizontal, bits 21:16 vertical).
- Control register:
  - bit 2: enable.
  - bit 10: forced blank.
  - bit 12: horizontal sync polarity.
  - bit 13: vertical sync polarity.
  - bits 1:0: pixel depth, where 0 is 8 bpp, 1 is 16 bpp, 2 is 32 bpp and 3 is invalid.

Top module: `crtc_timing`

## Requirements
- R1: After reset the control register reads 0x00010000. Indices 1 to 5 read 0. `active_video` is low, `px_x` and `px_y` are 0, and both sync outputs are low.
- R2: Writes are masked before storage: control with 0x0003FFFF, both totals with 0x0FFF0FFF, horizontal sync with 0x00FF0FFF and vertical sync with 0x003F0FFF. Index 5 ignores writes, and indices 6 and 7 read 0.
- R3: While running, `px_x` counts 0 up to horizontal total bits 27:16 and then wraps to 0. Each wrap advances `px_y`, which counts 0 up to vertical total bits 27:16 and then wraps.
- R4: `active_video` is high only when `px_x` is at most horizontal total bits 11:0 and `px_y` is at most vertical total bits 11:0.
- R5: The raw horizontal sync is true for `px_x` in [start, start+width), with start from bits 11:0 and width from bits 23:16. The raw vertical sync is true for `px_y` in [start, start+width), with width from bits 21:16.
- R6: With control bit 12 clear, `hsync` equals the raw pulse; with it set, `hsync` is inverted. Control bit 13 does the same for `vsync`.
- R7: Control bit 10 set holds `active_video` low while the counters and syncs keep running.
- R8: A pixel depth code of 3 in control bits 1:0 holds `active_video` low.
- R9: With control bit 2 clear, the counters hold at 0, `active_video` is low and both syncs sit at their inactive level. Clearing the bit stops the raster on the next cycle. After the bit is set, pixel (0,0) is presented in the second cycle after the write edge.
- R10: A write made while running reads back at once, but the counters only use it from the start of the next frame.
- R11: Index 5 reads the current line number. That number equals `px_y` and changes only on a horizontal wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write index |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register read index |
| rd_data | output | 32 | register read data (combinational) |
| hsync | output | 1 | horizontal sync, polarity per control bit 12 |
| vsync | output | 1 | vertical sync, polarity per control bit 13 |
| active_video | output | 1 | pixel is inside the displayed area |
| px_x | output | 12 | current horizontal counter |
| px_y | output | 12 | current vertical counter |

## Verification
The assertions take for granted that reset is applied before the first write. They also assume that software does not write a timing register on the very cycle that closes a frame, which would merely push that write out by one frame. The stimulus keeps every active size no larger than its total and every sync window inside its line or frame. It writes during a frame only in the middle of a line. Every configuration is checked pixel by pixel over two whole frames against a model built from the field definitions.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HSW_W  = 8;
  localparam int unsigned VSW_W  = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_HTOT  = 3'd1,
    RA_HSYNC = 3'd2,
    RA_VTOT  = 3'd3,
    RA_VSYNC = 3'd4,
    RA_LINE  = 3'd5
  } reg_addr_e;

  localparam logic [REG_W-1:0] MASK_CTRL  = 32'h0003_FFFF;
  localparam logic [REG_W-1:0] MASK_TOT   = 32'h0FFF_0FFF;
  localparam logic [REG_W-1:0] MASK_HSYNC = 32'h00FF_0FFF;
  localparam logic [REG_W-1:0] MASK_VSYNC = 32'h003F_0FFF;
  localparam logic [REG_W-1:0] CTRL_RST   = 32'h0001_0000;

  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_BLANK = 10;
  localparam int unsigned CB_HPOL  = 12;
  localparam int unsigned CB_VPOL  = 13;
  localparam int unsigned LEN_LSB  = 16;

  typedef struct packed {
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] htot;
    logic [REG_W-1:0] hsync;
    logic [REG_W-1:0] vtot;
    logic [REG_W-1:0] vsync;
  } crtc_cfg_t;

endpackage

// File: rtl/crtc_axis_cnt.sv
module crtc_axis_cnt #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  assign wrap = adv && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (adv)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/crtc_sync_win.sv
module crtc_sync_win #(
  parameter int unsigned CW = 12,
  parameter int unsigned WW = 8
) (
  input  logic          run,
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] start,
  input  logic [WW-1:0] width,
  input  logic          pol,
  output logic          sync_o
);

  localparam int unsigned PAD = CW + 1 - WW;

  logic [CW:0] stop;
  logic        in_win;

  assign stop   = {1'b0, start} + {{PAD{1'b0}}, width};
  assign in_win = run && (pos >= start) && ({1'b0, pos} < stop);
  assign sync_o = in_win ^ pol;

endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              load,
  output crtc_cfg_t         shadow,
  output crtc_cfg_t         active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow      <= '0;
      shadow.ctrl <= CTRL_RST;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL:  shadow.ctrl  <= wr_data & MASK_CTRL;
        RA_HTOT:  shadow.htot  <= wr_data & MASK_TOT;
        RA_HSYNC: shadow.hsync <= wr_data & MASK_HSYNC;
        RA_VTOT:  shadow.vtot  <= wr_data & MASK_TOT;
        RA_VSYNC: shadow.vsync <= wr_data & MASK_VSYNC;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= '0;
      active.ctrl <= CTRL_RST;
    end else if (load) begin
      active <= shadow;
    end
  end

endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic              active_video,
  output logic [CW-1:0]     px_x,
  output logic [CW-1:0]     px_y
);

  crtc_cfg_t     sh_cfg;
  crtc_cfg_t     act_cfg;
  logic          run;
  logic          load;
  logic          h_wrap;
  logic          v_wrap;
  logic          frame_end;
  logic [CW-1:0] cur_line;
  logic          in_area;
  logic          depth_bad;

  // Stop at once when software clears enable; start only once the working copy agrees.
  assign run       = sh_cfg.ctrl[CB_EN] && act_cfg.ctrl[CB_EN];
  assign frame_end = h_wrap && v_wrap;
  assign load      = !run || frame_end;

  crtc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load),
    .shadow  (sh_cfg),
    .active  (act_cfg)
  );

  crtc_axis_cnt #(.CW(CW)) u_hcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .adv   (run),
    .last  (act_cfg.htot[LEN_LSB +: CW]),
    .cnt   (px_x),
    .wrap  (h_wrap)
  );

  crtc_axis_cnt #(.CW(CW)) u_vcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .adv   (h_wrap),
    .last  (act_cfg.vtot[LEN_LSB +: CW]),
    .cnt   (px_y),
    .wrap  (v_wrap)
  );

  crtc_sync_win #(.CW(CW), .WW(HSW_W)) u_hs (
    .run    (run),
    .pos    (px_x),
    .start  (act_cfg.hsync[CW-1:0]),
    .width  (act_cfg.hsync[LEN_LSB +: HSW_W]),
    .pol    (act_cfg.ctrl[CB_HPOL]),
    .sync_o (hsync)
  );

  crtc_sync_win #(.CW(CW), .WW(VSW_W)) u_vs (
    .run    (run),
    .pos    (px_y),
    .start  (act_cfg.vsync[CW-1:0]),
    .width  (act_cfg.vsync[LEN_LSB +: VSW_W]),
    .pol    (act_cfg.ctrl[CB_VPOL]),
    .sync_o (vsync)
  );

  // Line status register: refreshed only on a horizontal wrap.
  always_ff @(posedge clk) begin
    if (!rst_n)      cur_line <= '0;
    else if (!run)   cur_line <= '0;
    else if (h_wrap) cur_line <= v_wrap ? '0 : cur_line + 1'b1;
  end

  assign in_area      = (px_x <= act_cfg.htot[CW-1:0]) && (px_y <= act_cfg.vtot[CW-1:0]);
  assign depth_bad    = (act_cfg.ctrl[1:0] == 2'b11);
  assign active_video = run && in_area && !act_cfg.ctrl[CB_BLANK] && !depth_bad;

  always_comb begin
    case (rd_addr)
      RA_CTRL:  rd_data = sh_cfg.ctrl;
      RA_HTOT:  rd_data = sh_cfg.htot;
      RA_HSYNC: rd_data = sh_cfg.hsync;
      RA_VTOT:  rd_data = sh_cfg.vtot;
      RA_VSYNC: rd_data = sh_cfg.vsync;
      RA_LINE:  rd_data = {{(REG_W-CW){1'b0}}, cur_line};
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] px_x,
  input logic [CW-1:0] px_y,
  input logic          de,
  input logic [CW-1:0] cur_line,
  input logic [31:0]   act_ctrl,
  input logic [31:0]   act_htot,
  input logic [31:0]   act_vtot
);

  assert_x_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && px_x != '0) |-> (px_x == $past(px_x) + 1'b1));

  assert_de_in_area_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (px_x <= act_htot[CW-1:0] && px_y <= act_vtot[CW-1:0]));

  assert_blank_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_ctrl[10] |-> !de);

  assert_bad_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ctrl[1:0] == 2'b11) |-> !de);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (px_x == '0 && px_y == '0));

  assert_cfg_frame_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (px_x != '0 || px_y != '0)) |->
      ($stable(act_htot) && $stable(act_vtot) && $stable(act_ctrl)));

  assert_line_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_line == px_y);

  assert_line_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && px_x != '0) |-> $stable(cur_line));

endmodule

bind crtc_timing crtc_timing_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .px_x     (px_x),
  .px_y     (px_y),
  .de       (active_video),
  .cur_line (cur_line),
  .act_ctrl (act_cfg.ctrl),
  .act_htot (act_cfg.htot),
  .act_vtot (act_cfg.vtot)
);

// File: tb/crtc_timing_tb.sv
`timescale 1ns/1ps
module crtc_timing_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        hsync, vsync, active_video;
  logic [11:0] px_x, px_y;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  crtc_timing dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync),
    .active_video(active_video), .px_x(px_x), .px_y(px_y)
  );

  // {ctrl, htot, hsync, vtot, vsync}
  localparam logic [159:0] VEC [4] = '{
    {32'h0000_0005, 32'h000F_0009, 32'h0002_000B, 32'h0007_0004, 32'h0001_0005},
    {32'h0000_3006, 32'h0013_000F, 32'h0003_0010, 32'h0005_0003, 32'h0002_0004},
    {32'h0000_0404, 32'h0009_0005, 32'h0001_0007, 32'h0004_0002, 32'h0001_0003},
    {32'h0000_1007, 32'h000B_0007, 32'h0002_0008, 32'h0003_0001, 32'h0001_0002}
  };

  task automatic check(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic bit in_win(int p, int s, int w);
    return (p >= s) && (p < s + w);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 32'h0001_0000);
    for (int a = 1; a <= 5; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 de", active_video, 0);
    check("R1 x", px_x, 0);
    check("R1 y", px_y, 0);
    check("R1 hsync", hsync, 0);
    check("R1 vsync", vsync, 0);

    // R2 write masks
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); check("R2 htot", d, 32'h0FFF_0FFF);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R2 hsync", d, 32'h00FF_0FFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); check("R2 vtot", d, 32'h0FFF_0FFF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); check("R2 vsync", d, 32'h003F_0FFF);
    wr(3'd0, 32'hFFFF_FFFB); rd(3'd0, d); check("R2 ctrl", d, 32'h0003_FFFB);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, d); check("R2 line ignores write", d, 0);
    rd(3'd6, d); check("R2 unmapped", d, 0);
    check("R9 idle de", active_video, 0);
    wr(3'd0, 32'h0);

    // Vector table: two full frames per configuration
    for (int i = 0; i < 4; i++) begin
      logic [31:0] c, ht, hs, vt, vs;
      int hl, vl, ha, va, hss, hsw, vss, vsw, fr;
      bit blank;
      {c, ht, hs, vt, vs} = VEC[i];
      hl = int'(ht[27:16]); ha = int'(ht[11:0]);
      vl = int'(vt[27:16]); va = int'(vt[11:0]);
      hss = int'(hs[11:0]); hsw = int'(hs[23:16]);
      vss = int'(vs[11:0]); vsw = int'(vs[21:16]);
      blank = c[10] || (c[1:0] == 2'b11);
      fr = (hl + 1) * (vl + 1);
      wr(3'd1, ht); wr(3'd2, hs); wr(3'd3, vt); wr(3'd4, vs);
      wr(3'd0, c);
      check("R9 not yet running", active_video, 0);
      rd_addr = 3'd5;
      for (int k = 0; k < 2 * fr; k++) begin
        int h, v;
        @(negedge clk);
        h = k % (hl + 1);
        v = (k / (hl + 1)) % (vl + 1);
        check("R3 px_x", px_x, h);
        check("R3 px_y", px_y, v);
        check("R4 R7 R8 active_video", active_video, (h <= ha && v <= va && !blank) ? 1 : 0);
        check("R5 R6 hsync", hsync, in_win(h, hss, hsw) ^ c[12]);
        check("R5 R6 vsync", vsync, in_win(v, vss, vsw) ^ c[13]);
        check("R11 line readback", rd_data, v);
      end
      wr(3'd0, 32'h0);
      @(negedge clk);
      check("R9 stop x", px_x, 0);
      check("R9 stop y", px_y, 0);
      check("R9 stop de", active_video, 0);
      check("R9 stop hsync", hsync, 0);
      check("R9 stop vsync", vsync, 0);
    end

    // R10: a mid-frame write waits for the next frame
    wr(3'd1, 32'h000F_0009); wr(3'd2, 32'h0001_0001);
    wr(3'd3, 32'h0007_0004); wr(3'd4, 32'h0001_0001);
    wr(3'd0, 32'h0000_0004);
    @(negedge clk);                        // k = 0
    wr(3'd1, 32'h0007_0003);               // returns at k = 2
    rd(3'd1, d); check("R10 readback immediate", d, 32'h0007_0003);
    for (int k = 3; k < 128 + 20; k++) begin
      @(negedge clk);
      if (k == 15)  check("R10 old length kept x", px_x, 15);
      if (k == 16)  check("R10 old length kept y", px_y, 1);
      if (k == 9)   check("R10 old active kept", active_video, 1);
      if (k == 128) begin check("R10 new frame x", px_x, 0); check("R10 new frame y", px_y, 0); end
      if (k == 131) check("R10 new active edge in", active_video, 1);
      if (k == 132) check("R10 new active edge out", active_video, 0);
      if (k == 135) check("R10 new length x", px_x, 7);
      if (k == 136) begin check("R10 new wrap x", px_x, 0); check("R10 new wrap y", px_y, 1); end
    end
    // R9: clearing enable stops on the next cycle
    wr(3'd0, 32'h0);
    check("R9 immediate de", active_video, 0);
    @(negedge clk);
    check("R9 cleared x", px_x, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule